// File: doc/BRIEF.md
# Ethernet PHY Link Bring-Up Sequencer

This block brings an Ethernet PHY from reset to a resolved link without software. A start pulse launches a fixed sequence of management-register transactions. The sequence resets the PHY and waits for the reset to finish. It then checks that a cable is present, advertises every 10/100 ability and restarts auto-negotiation. It waits for negotiation and link, then reads the partner's abilities and settles on a speed and duplex. The results are a speed bit, a duplex bit and three sticky status flags: done, no-link and error. Software or other hardware reads these flags after the sequence ends.

Transactions leave through a request port that follows valid/ready rules. The block raises `mreq_valid` with the command fields. It holds the valid bit and all fields unchanged until a cycle where `mreq_ready` is high, and that cycle transfers the request. Only one transaction is outstanding at a time. The external management master answers every transfer, whether read or write, with one cycle of `mrsp_valid`. For reads that cycle also carries `mrsp_rdata`. The block always accepts a response, so the response path has no back-pressure. Serial framing on the management wires is the job of that separate master.

Top module: `phy_link_seq`

## Requirements
- R1: A `start` pulse in idle raises `busy` on the next edge, and the first request is a write of 0x8000 (bit 15 set) to register 0. Every request carries the PHY address given by parameter `PHY_ADDR`.
- R2: After the reset write, register 0 is read repeatedly until bit 15 reads 0. Register 0 is then not read again until the read-modify-write of R5.
- R3: Register 1 is then read once. If bit 3 (link valid) is 0, the sequence ends with `no_link`=1, `done`=1, `link_speed100`=0 and `link_full`=0, and it issues no further requests.
- R4: With the link present, the block writes register 4 with 0x01E1: bits 8, 7, 6 and 5 advertise 100 full, 100 half, 10 full and 10 half, and bit 0 is the CSMA/CD selector.
- R5: Auto-negotiation restarts by reading register 0 and writing back the same value with bit 9 set.
- R6: Register 1 is polled until bit 5 (negotiation complete) is 1, and then polled until bit 3 (link valid) is 1.
- R7: Register 5 is read and resolved with fixed priority. Bit 8 gives 100 full. Otherwise bit 7 gives 100 half. Otherwise bit 6 gives 10 full. Otherwise the result is 10 half. 100 Mb/s is `link_speed100`=1 and full duplex is `link_full`=1.
- R8: Each poll loop (R2, R6) counts cycles from its entry. If a poll result does not meet its condition once `tmo_limit` cycles have passed, the block raises `error`, leaves `done` low and returns to idle.
- R9: `start` is ignored while `busy`. `done`, `error` and `no_link` hold their values in idle until the next accepted `start`, which clears them. `done` and `error` are never high while `busy`.
- R10: An offered request stays valid with stable fields until it is accepted, and the sequence completes correctly under any ready pattern and response delay.
- R11: After reset, `busy`, `done`, `error`, `no_link`, the speed and duplex bits and `mreq_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, honoured only in idle |
| tmo_limit | input | TMO_W | Poll loop timeout in cycles |
| mreq_valid | output | 1 | Request offered |
| mreq_ready | input | 1 | Management master accepts request |
| mreq_write | output | 1 | 1 = write, 0 = read |
| mreq_phy | output | 5 | PHY address |
| mreq_reg | output | 5 | PHY register number |
| mreq_wdata | output | 16 | Write data |
| mrsp_valid | input | 1 | One-cycle completion of the outstanding request |
| mrsp_rdata | input | 16 | Read data, valid with `mrsp_valid` |
| busy | output | 1 | Sequence running |
| done | output | 1 | Sequence finished without error (sticky) |
| no_link | output | 1 | No cable found at the first status check (sticky) |
| error | output | 1 | A poll loop timed out (sticky) |
| link_speed100 | output | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| link_full | output | 1 | 1 = full duplex, 0 = half duplex |

## Verification
`busy` rises on the first edge after `start`, and the reset write is offered in that same cycle. `done`, `error`, `no_link` and the speed and duplex bits change on the edge after the one that accepts the final response, which is the same edge where `busy` falls. The behavioural PHY model varies both the ready gating and the response delay, so the time to finish depends on the scenario. The bench therefore waits at falling edges for `busy` to drop, with a bounded wait, before it checks the result flags and the transaction counts. Held flags are sampled again twenty cycles later, and a restart is checked one falling edge after the `start` pulse.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RST_WR,
    S_RST_RD,
    S_LNK0_RD,
    S_ADV_WR,
    S_CTL_RD,
    S_CTL_WR,
    S_AN_RD,
    S_LNK_RD,
    S_LP_RD
  } seq_state_t;

  typedef struct packed {
    logic        wr;
    logic [4:0]  regno;
    logic [15:0] wdata;
  } mgmt_cmd_t;

  localparam logic [4:0] REG_CTL = 5'd0;
  localparam logic [4:0] REG_STS = 5'd1;
  localparam logic [4:0] REG_ADV = 5'd4;
  localparam logic [4:0] REG_LP  = 5'd5;

  localparam int CTL_RESET_BIT   = 15;
  localparam int CTL_RESTART_BIT = 9;
  localparam int STS_LINK_BIT    = 3;
  localparam int STS_ANDONE_BIT  = 5;
  localparam int LP_100F_BIT     = 8;
  localparam int LP_10F_BIT      = 6;

  localparam logic [15:0] ADV_VALUE = (16'h1 << 8) | (16'h1 << 7) |
                                      (16'h1 << 6) | (16'h1 << 5) | 16'h1;

endpackage

// File: rtl/phy_seq_cmd.sv
module phy_seq_cmd
  import phy_seq_pkg::*;
(
  input  seq_state_t  st,
  input  logic [15:0] ctl_q,
  output logic        issue,
  output mgmt_cmd_t   cmd
);
  always_comb begin
    issue = 1'b1;
    cmd   = '{wr: 1'b0, regno: REG_CTL, wdata: 16'h0000};
    case (st)
      S_RST_WR: begin
        cmd.wr    = 1'b1;
        cmd.wdata = 16'h0001 << CTL_RESET_BIT;
      end
      S_RST_RD, S_CTL_RD: cmd.regno = REG_CTL;
      S_LNK0_RD, S_AN_RD, S_LNK_RD: cmd.regno = REG_STS;
      S_ADV_WR: begin
        cmd.wr    = 1'b1;
        cmd.regno = REG_ADV;
        cmd.wdata = ADV_VALUE;
      end
      S_CTL_WR: begin
        cmd.wr    = 1'b1;
        cmd.wdata = ctl_q | (16'h0001 << CTL_RESTART_BIT);
      end
      S_LP_RD: cmd.regno = REG_LP;
      default: issue = 1'b0;
    endcase
  end
endmodule

// File: rtl/phy_seq_port.sv
module phy_seq_port (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  input  logic mreq_ready,
  input  logic mrsp_valid,
  output logic mreq_valid,
  output logic rsp_fire
);
  logic waiting_q;

  assign mreq_valid = issue && !waiting_q;
  assign rsp_fire   = waiting_q && mrsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      waiting_q <= 1'b0;
    else if (mreq_valid && mreq_ready) waiting_q <= 1'b1;
    else if (rsp_fire)               waiting_q <= 1'b0;
  end
endmodule

// File: rtl/phy_seq_timer.sv
module phy_seq_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  localparam logic [TMO_W-1:0] CNT_MAX = '1;
  logic [TMO_W-1:0] cnt_q;

  assign expired = (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr)              cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/phy_seq_resolve.sv
module phy_seq_resolve (
  input  logic [2:0] abil,
  output logic       speed100,
  output logic       full
);
  always_comb begin
    if (abil[2])      begin speed100 = 1'b1; full = 1'b1; end
    else if (abil[1]) begin speed100 = 1'b1; full = 1'b0; end
    else if (abil[0]) begin speed100 = 1'b0; full = 1'b1; end
    else              begin speed100 = 1'b0; full = 1'b0; end
  end
endmodule

// File: rtl/phy_link_seq.sv
module phy_link_seq
  import phy_seq_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR = 5'd1,
  parameter int         TMO_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             mreq_valid,
  input  logic             mreq_ready,
  output logic             mreq_write,
  output logic [4:0]       mreq_phy,
  output logic [4:0]       mreq_reg,
  output logic [15:0]      mreq_wdata,
  input  logic             mrsp_valid,
  input  logic [15:0]      mrsp_rdata,
  output logic             busy,
  output logic             done,
  output logic             no_link,
  output logic             error,
  output logic             link_speed100,
  output logic             link_full
);
  seq_state_t  st_q, st_d;
  mgmt_cmd_t   cmd;
  logic        issue, rsp_fire, tmr_exp;
  logic [15:0] ctl_q;
  logic        res_spd, res_full;
  logic        set_err, set_nl, set_res, launch;

  phy_seq_cmd u_cmd (.st(st_q), .ctl_q(ctl_q), .issue(issue), .cmd(cmd));

  phy_seq_port u_port (
    .clk(clk), .rst_n(rst_n), .issue(issue), .mreq_ready(mreq_ready),
    .mrsp_valid(mrsp_valid), .mreq_valid(mreq_valid), .rsp_fire(rsp_fire)
  );

  phy_seq_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(st_d != st_q), .limit(tmo_limit),
    .expired(tmr_exp)
  );

  phy_seq_resolve u_res (
    .abil(mrsp_rdata[LP_100F_BIT:LP_10F_BIT]), .speed100(res_spd), .full(res_full)
  );

  assign mreq_write = cmd.wr;
  assign mreq_reg   = cmd.regno;
  assign mreq_wdata = cmd.wdata;
  assign mreq_phy   = PHY_ADDR;
  assign busy       = (st_q != S_IDLE);
  assign launch     = (st_q == S_IDLE) && start;

  always_comb begin
    st_d    = st_q;
    set_err = 1'b0;
    set_nl  = 1'b0;
    set_res = 1'b0;
    case (st_q)
      S_IDLE:   if (start) st_d = S_RST_WR;
      S_RST_WR: if (rsp_fire) st_d = S_RST_RD;
      S_RST_RD: if (rsp_fire) begin
        if (!mrsp_rdata[CTL_RESET_BIT]) st_d = S_LNK0_RD;
        else if (tmr_exp) begin st_d = S_IDLE; set_err = 1'b1; end
      end
      S_LNK0_RD: if (rsp_fire) begin
        if (mrsp_rdata[STS_LINK_BIT]) st_d = S_ADV_WR;
        else begin st_d = S_IDLE; set_nl = 1'b1; end
      end
      S_ADV_WR: if (rsp_fire) st_d = S_CTL_RD;
      S_CTL_RD: if (rsp_fire) st_d = S_CTL_WR;
      S_CTL_WR: if (rsp_fire) st_d = S_AN_RD;
      S_AN_RD: if (rsp_fire) begin
        if (mrsp_rdata[STS_ANDONE_BIT]) st_d = S_LNK_RD;
        else if (tmr_exp) begin st_d = S_IDLE; set_err = 1'b1; end
      end
      S_LNK_RD: if (rsp_fire) begin
        if (mrsp_rdata[STS_LINK_BIT]) st_d = S_LP_RD;
        else if (tmr_exp) begin st_d = S_IDLE; set_err = 1'b1; end
      end
      S_LP_RD: if (rsp_fire) begin st_d = S_IDLE; set_res = 1'b1; end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= S_IDLE;
      ctl_q         <= '0;
      done          <= 1'b0;
      error         <= 1'b0;
      no_link       <= 1'b0;
      link_speed100 <= 1'b0;
      link_full     <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == S_CTL_RD && rsp_fire) ctl_q <= mrsp_rdata;
      if (launch) begin
        done          <= 1'b0;
        error         <= 1'b0;
        no_link       <= 1'b0;
        link_speed100 <= 1'b0;
        link_full     <= 1'b0;
      end else if (set_err) begin
        error <= 1'b1;
      end else if (set_nl) begin
        no_link       <= 1'b1;
        done          <= 1'b1;
        link_speed100 <= 1'b0;
        link_full     <= 1'b0;
      end else if (set_res) begin
        done          <= 1'b1;
        link_speed100 <= res_spd;
        link_full     <= res_full;
      end
    end
  end
endmodule

// File: rtl/phy_link_seq_chk.sv
module phy_link_seq_chk #(
  parameter logic [4:0] PHY_ADDR = 5'd1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        error,
  input logic        no_link,
  input logic        link_speed100,
  input logic        link_full,
  input logic        mreq_valid,
  input logic        mreq_ready,
  input logic        mreq_write,
  input logic [4:0]  mreq_phy,
  input logic [4:0]  mreq_reg,
  input logic [15:0] mreq_wdata
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && !mreq_ready |=> mreq_valid &&
      $stable({mreq_write, mreq_reg, mreq_wdata})); // R10

  AST_FIRST_RESET_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> mreq_valid && mreq_write && mreq_reg == 5'd0 &&
      mreq_wdata == 16'h8000); // R1

  AST_PHY_ADDRESS: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |-> mreq_phy == PHY_ADDR); // R1

  AST_NO_FLAGS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done && !error); // R9

  AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done); // R9

  AST_NOLINK_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    no_link |-> done && !link_speed100 && !link_full); // R3

  AST_ERROR_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !done && !busy); // R8
endmodule

bind phy_link_seq phy_link_seq_chk #(.PHY_ADDR(PHY_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .error(error), .no_link(no_link), .link_speed100(link_speed100),
  .link_full(link_full), .mreq_valid(mreq_valid), .mreq_ready(mreq_ready),
  .mreq_write(mreq_write), .mreq_phy(mreq_phy), .mreq_reg(mreq_reg),
  .mreq_wdata(mreq_wdata)
);

// File: tb/sim_phy_link_seq.sv
`timescale 1ns/1ps
module sim_phy_link_seq;
  localparam logic [4:0]  PHY = 5'd1;
  localparam logic [15:0] CTL_BASE = 16'h3100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] tmo_limit = 16'd1000;
  logic mreq_valid, mreq_ready, mreq_write;
  logic [4:0] mreq_phy, mreq_reg;
  logic [15:0] mreq_wdata;
  logic mrsp_valid = 1'b0;
  logic [15:0] mrsp_rdata = 16'h0;
  logic busy, done, no_link, error, link_speed100, link_full;

  always #2 clk = ~clk;

  phy_link_seq #(.PHY_ADDR(PHY), .TMO_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .tmo_limit(tmo_limit),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_write(mreq_write),
    .mreq_phy(mreq_phy), .mreq_reg(mreq_reg), .mreq_wdata(mreq_wdata),
    .mrsp_valid(mrsp_valid), .mrsp_rdata(mrsp_rdata), .busy(busy), .done(done),
    .no_link(no_link), .error(error), .link_speed100(link_speed100),
    .link_full(link_full)
  );

  // PHY model configuration (written only by the stimulus)
  int cfg_rst_polls = 0, cfg_an_polls = 0, cfg_lnk_polls = 0, cfg_dly = 0;
  logic [15:0] cfg_lp = 16'h0;
  logic cfg_link = 1'b1, cfg_slow = 1'b0, log_clr = 1'b0;

  // PHY model state and logs (written only by the model)
  logic m_busy = 1'b0, rdy_gate = 1'b1;
  int m_wait = 0, rst_left = 0, an_left = 0, lnk_left = 0;
  logic an_on = 1'b0, an_seen = 1'b0, first_seen = 1'b0;
  logic m_wr = 1'b0;
  logic [4:0] m_reg = 5'd0;
  logic [15:0] m_wd = 16'h0, rv;
  logic [21:0] first_cmd = '0;
  int n_rst_wr = 0, n_ctl_rd = 0, n_sts_rd = 0, n_adv_wr = 0, n_lp_rd = 0, bad_addr = 0;
  logic [15:0] adv_val = 16'h0, rmw_val = 16'h0;

  assign mreq_ready = !m_busy && rdy_gate;

  always @(posedge clk) begin
    mrsp_valid <= 1'b0;
    rdy_gate <= cfg_slow ? ~rdy_gate : 1'b1;
    if (log_clr) begin
      n_rst_wr = 0; n_ctl_rd = 0; n_sts_rd = 0; n_adv_wr = 0; n_lp_rd = 0;
      bad_addr = 0; adv_val = 16'h0; rmw_val = 16'h0; first_seen = 1'b0;
      rst_left = 0; an_left = 0; lnk_left = 0; an_on = 1'b0; an_seen = 1'b0;
    end
    if (!m_busy) begin
      if (mreq_valid && mreq_ready) begin
        m_busy <= 1'b1;
        m_wait = cfg_dly;
        m_wr = mreq_write; m_reg = mreq_reg; m_wd = mreq_wdata;
        if (mreq_phy != PHY) bad_addr++;
        if (!first_seen) begin
          first_seen = 1'b1;
          first_cmd = {mreq_write, mreq_reg, mreq_wdata};
        end
      end
    end else if (m_wait == 0) begin
      rv = 16'h0;
      if (m_wr) begin
        if (m_reg == 5'd0) begin
          if (m_wd[15]) begin n_rst_wr++; rst_left = cfg_rst_polls; end
          if (m_wd[9]) begin
            rmw_val = m_wd; an_on = 1'b1; an_seen = 1'b0;
            an_left = cfg_an_polls; lnk_left = cfg_lnk_polls;
          end
        end else if (m_reg == 5'd4) begin
          n_adv_wr++; adv_val = m_wd;
        end
      end else begin
        case (m_reg)
          5'd0: begin
            n_ctl_rd++;
            if (rst_left > 0) begin rst_left--; rv = 16'h8000 | CTL_BASE; end
            else rv = CTL_BASE;
          end
          5'd1: begin
            n_sts_rd++;
            if (!an_on) rv = cfg_link ? 16'h0008 : 16'h0000;
            else if (an_left > 0) begin an_left--; rv = 16'h0000; end
            else if (!an_seen) begin an_seen = 1'b1; rv = (lnk_left > 0) ? 16'h0020 : 16'h002C; end
            else if (lnk_left > 0) begin lnk_left--; rv = 16'h0020; end
            else rv = 16'h002C;
          end
          5'd5: begin n_lp_rd++; rv = cfg_lp; end
          default: rv = 16'hFFFF;
        endcase
      end
      m_busy <= 1'b0;
      mrsp_valid <= 1'b1;
      mrsp_rdata <= rv;
    end else begin
      m_wait--;
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic launch(input logic [15:0] lp, input logic link, input int rp,
                        input int ap, input int lk, input int dly, input logic slow,
                        input logic [15:0] lim, input logic mid_start);
    int waited;
    cfg_lp = lp; cfg_link = link; cfg_rst_polls = rp; cfg_an_polls = ap;
    cfg_lnk_polls = lk; cfg_dly = dly; cfg_slow = slow; tmo_limit = lim;
    @(negedge clk) log_clr = 1'b1;
    @(negedge clk) log_clr = 1'b0;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R9", "busy after start", int'(busy), 1);
    chk("R9", "done cleared by start", int'(done), 0);
    if (mid_start) begin
      repeat (6) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    waited = 0;
    while (busy && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    chk("R10", "sequence ended", int'(busy), 0);
  endtask

  task automatic t_reset();
    chk("R11", "busy", int'(busy), 0);
    chk("R11", "done", int'(done), 0);
    chk("R11", "error", int'(error), 0);
    chk("R11", "no_link", int'(no_link), 0);
    chk("R11", "speed/duplex", int'({link_speed100, link_full}), 0);
    chk("R11", "mreq_valid", int'(mreq_valid), 0);
  endtask

  task automatic t_full_run();
    launch(16'h01E1, 1'b1, 2, 3, 2, 1, 1'b0, 16'd1000, 1'b1);
    chk("R1", "first request", int'(first_cmd), int'({1'b1, 5'd0, 16'h8000}));
    chk("R1", "wrong phy address count", bad_addr, 0);
    chk("R9", "reset writes despite mid-run start", n_rst_wr, 1);
    chk("R2", "register 0 reads", n_ctl_rd, 2 + 2);
    chk("R4", "advertisement value", int'(adv_val), 16'h01E1);
    chk("R5", "restart write", int'(rmw_val), int'(CTL_BASE | 16'h0200));
    chk("R6", "status reads", n_sts_rd, 3 + 2 + 3);
    chk("R7", "100 full", int'({link_speed100, link_full}), 2'b11);
    chk("R7", "done", int'(done), 1);
    repeat (20) @(negedge clk);
    chk("R9", "done held", int'(done), 1);
  endtask

  task automatic t_priority();
    logic [15:0] lps [4] = '{16'h00C0, 16'h0040, 16'h0020, 16'h0180};
    logic [1:0]  exp [4] = '{2'b10, 2'b01, 2'b00, 2'b11};
    for (int i = 0; i < 4; i++) begin
      launch(lps[i], 1'b1, 0, 0, 0, 0, 1'b0, 16'd1000, 1'b0);
      chk("R7", "priority resolve", int'({link_speed100, link_full}), int'(exp[i]));
      chk("R7", "partner reads", n_lp_rd, 1);
    end
  endtask

  task automatic t_nolink();
    launch(16'h01E1, 1'b0, 1, 0, 0, 2, 1'b0, 16'd1000, 1'b0);
    chk("R3", "no_link", int'(no_link), 1);
    chk("R3", "done", int'(done), 1);
    chk("R3", "forced 10 half", int'({link_speed100, link_full}), 0);
    chk("R3", "no advertisement write", n_adv_wr, 0);
    chk("R3", "single status read", n_sts_rd, 1);
  endtask

  task automatic t_timeouts();
    launch(16'h01E1, 1'b1, 60, 0, 0, 1, 1'b0, 16'd30, 1'b0);
    chk("R8", "reset loop error", int'(error), 1);
    chk("R8", "done low", int'(done), 0);
    chk("R8", "stopped before status", n_sts_rd, 0);
    launch(16'h01E1, 1'b1, 0, 60, 0, 1, 1'b0, 16'd30, 1'b0);
    chk("R8", "negotiation loop error", int'(error), 1);
    chk("R8", "no partner read", n_lp_rd, 0);
    launch(16'h01E1, 1'b1, 0, 0, 60, 1, 1'b0, 16'd30, 1'b0);
    chk("R8", "link loop error", int'(error), 1);
    repeat (20) @(negedge clk);
    chk("R9", "error held", int'(error), 1);
  endtask

  task automatic t_backpressure();
    launch(16'h0080, 1'b1, 3, 2, 1, 3, 1'b1, 16'd1000, 1'b0);
    chk("R10", "error clear", int'(error), 0);
    chk("R10", "100 half under back-pressure", int'({link_speed100, link_full}), 2'b10);
    chk("R6", "status reads", n_sts_rd, 2 + 1 + 3);
    chk("R2", "register 0 reads", n_ctl_rd, 3 + 2);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_run();
    t_priority();
    t_nolink();
    t_timeouts();
    t_backpressure();
    finish_run();
  end
endmodule